// File: doc/BRIEF.md
# Two-Channel Event and Time-Base Timer

This block is a register-mapped timer with two independent channels fed from one clock. Both channels share a small 32-bit register bus and a single interrupt line. Each channel has its own 2-bit divider field. The divider passes the clock straight through or divides it by 4 or by 16.

Channel 1 is the event channel. Software sets a compare value and starts the channel. The channel counts divided ticks. On the tick where the count reaches the compare value, it sets a sticky flag, and that flag can raise the interrupt unless it is masked. Channel 2 is a free-running 32-bit time base, and software can read it at any moment.

Each channel is started by writing a one to its bit in a set register and stopped by writing a one to its bit in a separate clear register. A third register zeroes the counts. Register writes take effect on the clock edge where the write is presented. Reads are combinational from the address.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, both channels are stopped and both counts read 0. The divider register at 0x00 reads 0, the mask at 0x10 reads 1, the flag at 0x0C reads 0, the enable status at 0x34 reads 0, and `irq` is low.
- R2: The divider register at 0x00 is read/write. Bits [1:0] set channel 1 and bits [3:2] set channel 2. A field value n divides by 4^n: 0 gives /1, 1 gives /4 and 2 gives /16. Value 3 behaves as /16. A channel started from a count of 0 and run for k cycles reads floor(k / divide).
- R3: Writing address 0x34 starts channel 1 if data bit 0 is 1 and channel 2 if data bit 1 is 1. Zero bits leave their channel as it is. Reading 0x34 returns the run state in bits [1:0].
- R4: Writing a one to bit 0 (channel 1) or bit 1 (channel 2) of address 0x38 stops that channel, and its count then holds. A stopped channel's divider restarts, so after a restart the first tick comes a full divide period later.
- R5: Writing a one to bit 0 or bit 1 of address 0x08 zeroes the channel 1 or channel 2 count on that edge. This also applies while the channel runs, and the clear wins over a tick on the same edge.
- R6: The compare value is held at 0x14 (read/write). On the tick where the channel 1 count advances to the compare value, the flag (0x0C bit 0) sets. The flag stays set while counting continues.
- R7: A write to 0x0C with bit 0 equal to 0 clears the flag. A write with bit 0 equal to 1 leaves it unchanged. A match on the same edge wins over the clear.
- R8: `irq` is high exactly while the flag is 1 and the mask (0x10 bit 0) is 0.
- R9: Channel 2 is a 32-bit count at 0x20 that advances by one per divided tick and wraps modulo 2^32. Channel 1 reads at 0x18. Writes to either count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Channel 1 interrupt, flag and not masked |

## Verification
Random trials each pick a divider per channel, a run length and a compare value. The compare value may be zero, below the reached count or above it, so the trials separate the three dividers and the /16 alias of field value 3. They also separate match from no match and masked from unmasked interrupt. Every trial stops the channels while the divider is part-way through a period, so the next trial's exact counts show whether the divider restarted. Directed cases cover a single-bit start that must leave the other channel idle, a clear issued while counting, and a flag write with bit 0 at 1 versus 0. They also cover a stop and restart in the middle of a period, and writes to the read-only count addresses.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_DIV,
    RS_CLR,
    RS_FLAG,
    RS_MASK,
    RS_CMP,
    RS_CNT1,
    RS_CNT2,
    RS_ENSET,
    RS_ENCLR
  } reg_sel_e;

  localparam logic [7:0] OFS_DIV   = 8'h00;
  localparam logic [7:0] OFS_CLR   = 8'h08;
  localparam logic [7:0] OFS_FLAG  = 8'h0C;
  localparam logic [7:0] OFS_MASK  = 8'h10;
  localparam logic [7:0] OFS_CMP   = 8'h14;
  localparam logic [7:0] OFS_CNT1  = 8'h18;
  localparam logic [7:0] OFS_CNT2  = 8'h20;
  localparam logic [7:0] OFS_ENSET = 8'h34;
  localparam logic [7:0] OFS_ENCLR = 8'h38;
endpackage

// File: rtl/dtt_rst_sync.sv
module dtt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dtt_prescaler.sv
// Divides by 4^sel (sel clamped to MAX_SEL); counter held at zero while stopped.
module dtt_prescaler #(
  parameter int SEL_W   = 2,
  parameter int MAX_SEL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_MAX = 1 << (2 * MAX_SEL);
  localparam int CW      = $clog2(DIV_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  int            eff_sel;

  always_comb begin
    eff_sel = (int'(sel) > MAX_SEL) ? MAX_SEL : int'(sel);
    lim     = CW'((1 << (2 * eff_sel)) - 1);
    tick    = run && (cnt_q >= lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dtt_event_chan.sv
// Channel 1 count with compare and sticky flag.
module dtt_event_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             flag_q, flag_d, match;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    match   = tick && !clr && (cnt_inc == cmp);
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_inc;
    else           cnt_d = cnt_q;
    if (match)         flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/dtt_free_chan.sv
// Channel 2 wrapping time base.
module dtt_free_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 2,
  parameter int MAX_SEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int DIV_W = NUM_CH * SEL_W;

  logic              rst_core_n;
  reg_sel_e          rsel;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic              mask_q, mask_d;
  logic [NUM_CH-1:0] en_q, en_d, en_set, en_clr, cnt_clr, tick;
  logic              flag_wr0, flag;
  logic [DATA_W-1:0] cnt1, cnt2;

  dtt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n));

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_DIV))   rsel = RS_DIV;
    else if (bus_addr == ADDR_W'(OFS_CLR))   rsel = RS_CLR;
    else if (bus_addr == ADDR_W'(OFS_FLAG))  rsel = RS_FLAG;
    else if (bus_addr == ADDR_W'(OFS_MASK))  rsel = RS_MASK;
    else if (bus_addr == ADDR_W'(OFS_CMP))   rsel = RS_CMP;
    else if (bus_addr == ADDR_W'(OFS_CNT1))  rsel = RS_CNT1;
    else if (bus_addr == ADDR_W'(OFS_CNT2))  rsel = RS_CNT2;
    else if (bus_addr == ADDR_W'(OFS_ENSET)) rsel = RS_ENSET;
    else if (bus_addr == ADDR_W'(OFS_ENCLR)) rsel = RS_ENCLR;
    else                                     rsel = RS_NONE;
  end

  // write strobes
  always_comb begin
    en_set   = (bus_we && rsel == RS_ENSET) ? bus_wdata[NUM_CH-1:0] : '0;
    en_clr   = (bus_we && rsel == RS_ENCLR) ? bus_wdata[NUM_CH-1:0] : '0;
    cnt_clr  = (bus_we && rsel == RS_CLR)   ? bus_wdata[NUM_CH-1:0] : '0;
    flag_wr0 = bus_we && (rsel == RS_FLAG) && !bus_wdata[0];
  end

  // next state of the control registers
  always_comb begin
    div_d  = (bus_we && rsel == RS_DIV)  ? bus_wdata[DIV_W-1:0] : div_q;
    cmp_d  = (bus_we && rsel == RS_CMP)  ? bus_wdata            : cmp_q;
    mask_d = (bus_we && rsel == RS_MASK) ? bus_wdata[0]         : mask_q;
    en_d   = (en_q | en_set) & ~en_clr;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      div_q  <= '0;
      cmp_q  <= '0;
      mask_q <= 1'b1;
      en_q   <= '0;
    end else begin
      div_q  <= div_d;
      cmp_q  <= cmp_d;
      mask_q <= mask_d;
      en_q   <= en_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gen_psc
    dtt_prescaler #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_psc (
      .clk  (clk),
      .rst_n(rst_core_n),
      .run  (en_q[g]),
      .sel  (div_q[g*SEL_W +: SEL_W]),
      .tick (tick[g])
    );
  end

  dtt_event_chan #(.CNT_W(DATA_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick[0]),
    .clr     (cnt_clr[0]),
    .cmp     (cmp_q),
    .flag_clr(flag_wr0),
    .cnt     (cnt1),
    .flag    (flag)
  );

  dtt_free_chan #(.CNT_W(DATA_W)) u_base (
    .clk  (clk),
    .rst_n(rst_core_n),
    .tick (tick[1]),
    .clr  (cnt_clr[1]),
    .cnt  (cnt2)
  );

  always_comb begin
    case (rsel)
      RS_DIV:   bus_rdata = DATA_W'(div_q);
      RS_FLAG:  bus_rdata = DATA_W'(flag);
      RS_MASK:  bus_rdata = DATA_W'(mask_q);
      RS_CMP:   bus_rdata = cmp_q;
      RS_CNT1:  bus_rdata = cnt1;
      RS_CNT2:  bus_rdata = cnt2;
      RS_ENSET: bus_rdata = DATA_W'(en_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag && !mask_q;
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker (
  input logic        clk,
  input logic        rst_core_n,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic        irq,
  input logic [1:0]  en_q,
  input logic [1:0]  tick,
  input logic [3:0]  div_q,
  input logic [31:0] cnt1,
  input logic [31:0] cnt2,
  input logic        flag
);
  logic wr_clr0, wr_clr1, wr_flag0, wr_mask1, wr_set1;

  always_comb begin
    wr_clr0  = bus_we && bus_addr == 8'h08 && bus_wdata[0];
    wr_clr1  = bus_we && bus_addr == 8'h08 && bus_wdata[1];
    wr_flag0 = bus_we && bus_addr == 8'h0C && !bus_wdata[0];
    wr_mask1 = bus_we && bus_addr == 8'h10 && bus_wdata[0];
    wr_set1  = bus_we && bus_addr == 8'h34 && bus_wdata[1];
  end

  always @(posedge clk) begin
    if (!rst_core_n) begin
      assert_reset_idle_R1: assert (en_q == 2'b00 && !irq && cnt1 == '0 && cnt2 == '0);
    end
  end

  assert_div_gap_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick[0] && div_q[1:0] != 2'd0) |=> (!tick[0] || div_q[1:0] == 2'd0));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_set1 |=> en_q[1]);

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!en_q[0] && !wr_clr0) |=> $stable(cnt1));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_clr0 |=> (cnt1 == '0));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_flag0 && !tick[0]) |=> !flag);

  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_mask1 |=> !irq);

  assert_base_step_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick[1] && !wr_clr1) |=> (cnt2 == $past(cnt2) + 32'd1));
endmodule

bind dual_tick_timer dtt_checker u_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .en_q      (en_q),
  .tick      (tick),
  .div_q     (div_q),
  .cnt1      (cnt1),
  .cnt2      (cnt2),
  .flag      (flag)
);

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DIV = 8'h00, A_CLR = 8'h08, A_FLAG = 8'h0C, A_MASK = 8'h10,
                         A_CMP = 8'h14, A_CNT1 = 8'h18, A_CNT2 = 8'h20,
                         A_ENSET = 8'h34, A_ENCLR = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  dual_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int div_of(input int field);
    return (field >= 2) ? 16 : (1 << (2 * field));
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic run_trial(input int p1, input int p2, input int k,
                           input logic [31:0] cmpv, input bit mk);
    logic [31:0] v, held;
    int e1, e2;
    bit fl;
    wr(A_ENCLR, 32'h3);
    wr(A_CLR, 32'h3);
    wr(A_DIV, 32'((p2 << 2) | p1));
    wr(A_CMP, cmpv);
    wr(A_MASK, 32'(mk));
    wr(A_FLAG, 32'h0);
    rd(A_DIV, v);  check("R2", "divider readback", v, 32'((p2 << 2) | p1));
    wr(A_ENSET, 32'h3);
    repeat (k) @(negedge clk);
    e1 = k / div_of(p1);
    e2 = k / div_of(p2);
    fl = (cmpv != 0) && (int'(cmpv) <= e1);
    rd(A_CNT1, v); check("R2", "channel 1 count", v, 32'(e1));
    rd(A_CNT2, v); check("R9", "channel 2 count", v, 32'(e2));
    rd(A_FLAG, v); check("R6", "compare flag", v, 32'(fl));
    check("R8", "irq level", 32'(irq), 32'(fl && !mk));
    wr(A_ENCLR, 32'h3);
    rd(A_CNT1, held);
    repeat (15) @(negedge clk);
    rd(A_CNT1, v); check("R4", "stopped count holds", v, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int unsigned junk;
    junk = $urandom(32'h0C0FFEE5);
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_DIV, v);   check("R1", "divider", v, 0);
    rd(A_MASK, v);  check("R1", "mask", v, 1);
    rd(A_FLAG, v);  check("R1", "flag", v, 0);
    rd(A_ENSET, v); check("R1", "run state", v, 0);
    rd(A_CNT1, v);  check("R1", "count 1", v, 0);
    rd(A_CNT2, v);  check("R1", "count 2", v, 0);
    check("R1", "irq", 32'(irq), 0);

    // directed trials, including field 3 as /16
    run_trial(0, 1, 20, 32'd5, 1'b0);
    run_trial(3, 2, 70, 32'd4, 1'b0);
    run_trial(1, 3, 33, 32'd9, 1'b0);

    for (int i = 0; i < 25; i++) begin
      int p1, p2, k;
      logic [31:0] cmpv;
      p1 = int'($urandom % 4);
      p2 = int'($urandom % 4);
      k  = 1 + int'($urandom % 120);
      cmpv = 32'($urandom % (k / div_of(p1) + 3));
      run_trial(p1, p2, k, cmpv, 1'($urandom % 2));
    end

    // R3: single-bit start leaves the other channel idle
    wr(A_CLR, 32'h3); wr(A_DIV, 32'h0);
    wr(A_ENSET, 32'h1);
    repeat (10) @(negedge clk);
    rd(A_ENSET, v); check("R3", "only channel 1 runs", v, 32'h1);
    rd(A_CNT2, v);  check("R3", "channel 2 untouched", v, 0);
    rd(A_CNT1, v);  check("R3", "channel 1 counted", v, 10);
    wr(A_ENCLR, 32'h1);

    // R7 / R8 flag and mask
    run_trial(0, 0, 10, 32'd4, 1'b1);
    wr(A_FLAG, 32'h1);
    rd(A_FLAG, v); check("R7", "write 1 keeps flag", v, 1);
    check("R8", "masked irq low", 32'(irq), 0);
    wr(A_MASK, 32'h0);
    check("R8", "unmasked irq high", 32'(irq), 1);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); check("R7", "write 0 clears flag", v, 0);
    check("R8", "irq drops with flag", 32'(irq), 0);

    // R5 clear while running
    wr(A_CLR, 32'h3); wr(A_DIV, 32'h0);
    wr(A_ENSET, 32'h3);
    repeat (10) @(negedge clk);
    wr(A_CLR, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_CNT1, v); check("R5", "channel 1 restarted from 0", v, 5);
    rd(A_CNT2, v); check("R5", "channel 2 not cleared", v, 16);
    wr(A_CLR, 32'h2);
    rd(A_CNT2, v); check("R5", "channel 2 cleared", v, 0);
    wr(A_ENCLR, 32'h3);

    // R9 count addresses ignore writes
    rd(A_CNT2, a);
    wr(A_CNT2, 32'hDEAD_BEEF);
    rd(A_CNT2, v); check("R9", "count 2 write ignored", v, a);
    rd(A_CNT1, a);
    wr(A_CNT1, 32'h1234_5678);
    rd(A_CNT1, v); check("R9", "count 1 write ignored", v, a);

    // R4 divider restarts after a mid-period stop
    wr(A_CLR, 32'h3); wr(A_DIV, 32'h1);
    wr(A_ENSET, 32'h1);
    repeat (6) @(negedge clk);
    wr(A_ENCLR, 32'h1);
    rd(A_CNT1, v); check("R4", "count at stop", v, 1);
    wr(A_ENSET, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_CNT1, v); check("R4", "no early tick after restart", v, 1);
    @(negedge clk);
    rd(A_CNT1, v); check("R4", "tick after full period", v, 2);
    wr(A_ENCLR, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule